// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Timer

This block enforces four DDR turnaround constraints for a memory scheduler: write recovery before a precharge, write-to-read spacing within a rank, read-to-precharge spacing within a bank, and the minimum time between CKE transitions on a rank. The scheduler reports events as single-cycle strobes tagged with a rank and, where it matters, a bank. The block answers with permission flags that the scheduler checks before it issues a precharge, a read or a CKE change.

Each constraint is a down-counter. The event that starts it loads the programmed count after clamping it into its legal window. The matching flag is low while the counter is running and high once it reaches zero. The four counts and the exit-powerdown time are plain inputs. Recommended power-up settings are write recovery 6, write-to-read 4, read-to-precharge 4 and CKE width 3.

Top module: `dram_turnaround_timer`

## Requirements
- R1: The write-recovery count (5-bit `cfg_wr_rec`) is clamped into 5..16 before use: values below 5 act as 5 and values above 16 act as 16.
- R2: The write-to-read count (4-bit `cfg_wr2rd`) is clamped into 4..8.
- R3: The read-to-precharge count (4-bit `cfg_rd2pre`) is clamped into 4..8.
- R4: The CKE width count (4-bit `cfg_cke_w`) is clamped into 3..L, where L is `cfg_pd_exit` if that value is 3 or more, and 3 otherwise.
- R5: A `wr_done` strobe for (rank r, bank b) drives `pre_ok[r*BANKS+b]` low for exactly the clamped write-recovery count of cycles, starting the cycle after the strobe's edge.
- R6: A `rd_cas` strobe for (rank r, bank b) drives `pre_ok[r*BANKS+b]` low for the clamped read-to-precharge count. A bank's flag returns high only when both its write-recovery timer and its read-to-precharge timer have run out.
- R7: A `wr_done` strobe for rank r drives `rd_ok[r]` low for exactly the clamped write-to-read count of cycles, whatever the bank.
- R8: A `cke_chg` strobe for rank r drives `cke_ok[r]` low for exactly the clamped CKE width count of cycles.
- R9: An event that arrives while its timer is still running reloads that timer with the full clamped count.
- R10: After reset, every `pre_ok`, `rd_ok` and `cke_ok` bit is high.
- R11: An event has no effect on the flags of any other bank or rank, and a flag that is high stays high unless an event addressed to it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_rec | input | 5 | Write-recovery count |
| cfg_wr2rd | input | 4 | Write-to-read count |
| cfg_rd2pre | input | 4 | Read-to-precharge count |
| cfg_cke_w | input | 4 | Minimum CKE pulse width |
| cfg_pd_exit | input | 4 | Exit-powerdown time; upper bound for the CKE width |
| wr_done | input | 1 | Write data for one burst has completed |
| wr_rank | input | RW | Rank of the write |
| wr_bank | input | BW | Bank of the write |
| rd_cas | input | 1 | Read CAS issued |
| rd_rank | input | RW | Rank of the read |
| rd_bank | input | BW | Bank of the read |
| cke_chg | input | 1 | CKE level changed |
| cke_rank | input | RW | Rank whose CKE changed |
| pre_ok | output | RANKS*BANKS | Precharge allowed, one bit per bank at index rank*BANKS+bank |
| rd_ok | output | RANKS | Read allowed, one bit per rank |
| cke_ok | output | RANKS | CKE change allowed, one bit per rank |

## Verification
The bench builds the block with its defaults of 2 ranks and 4 banks per rank, so every flag index can be observed at once. It sweeps every value of the write-recovery field and every value of the three 4-bit counts. In the same sweep the exit-powerdown time runs against the CKE width, so that both the clamps and the bounds imposed through tXP are reached. Targeted sequences overlap a write with a later read on the same bank and repeat a write while its timer is still running, which brings the combined release and the reload within reach.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  localparam int unsigned CNT_W     = 5;
  localparam int unsigned WR_MIN    = 5;
  localparam int unsigned WR_MAX    = 16;
  localparam int unsigned W2R_MIN   = 4;
  localparam int unsigned W2R_MAX   = 8;
  localparam int unsigned R2P_MIN   = 4;
  localparam int unsigned R2P_MAX   = 8;
  localparam int unsigned CKE_MIN   = 3;

  typedef logic [CNT_W-1:0] cnt_t;

  // Force a raw count into [lo, hi].
  function automatic cnt_t clamp_cnt(input cnt_t v, input cnt_t lo, input cnt_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Upper bound of the CKE width: the exit time, never below the minimum.
  function automatic cnt_t cke_ceiling(input cnt_t pd_exit);
    return (pd_exit < cnt_t'(CKE_MIN)) ? cnt_t'(CKE_MIN) : pd_exit;
  endfunction
endpackage

// File: rtl/dtt_limits.sv
module dtt_limits
  import dtt_pkg::*;
(
  input  logic [4:0] cfg_wr_rec,
  input  logic [3:0] cfg_wr2rd,
  input  logic [3:0] cfg_rd2pre,
  input  logic [3:0] cfg_cke_w,
  input  logic [3:0] cfg_pd_exit,
  output cnt_t       lim_wr_rec,
  output cnt_t       lim_wr2rd,
  output cnt_t       lim_rd2pre,
  output cnt_t       lim_cke_w
);
  cnt_t cke_hi;

  always_comb begin
    cke_hi     = cke_ceiling(cnt_t'(cfg_pd_exit));
    lim_wr_rec = clamp_cnt(cnt_t'(cfg_wr_rec), cnt_t'(WR_MIN),  cnt_t'(WR_MAX));
    lim_wr2rd  = clamp_cnt(cnt_t'(cfg_wr2rd),  cnt_t'(W2R_MIN), cnt_t'(W2R_MAX));
    lim_rd2pre = clamp_cnt(cnt_t'(cfg_rd2pre), cnt_t'(R2P_MIN), cnt_t'(R2P_MAX));
    lim_cke_w  = clamp_cnt(cnt_t'(cfg_cke_w),  cnt_t'(CKE_MIN), cke_hi);
  end
endmodule

// File: rtl/dtt_countdown.sv
module dtt_countdown #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (start)          count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);
endmodule

// File: rtl/dram_turnaround_timer.sv
module dram_turnaround_timer
  import dtt_pkg::*;
#(
  parameter int unsigned RANKS = 2,
  parameter int unsigned BANKS = 4,
  localparam int unsigned RW = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int unsigned BW = (BANKS > 1) ? $clog2(BANKS) : 1,
  localparam int unsigned NB = RANKS * BANKS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    cfg_wr_rec,
  input  logic [3:0]    cfg_wr2rd,
  input  logic [3:0]    cfg_rd2pre,
  input  logic [3:0]    cfg_cke_w,
  input  logic [3:0]    cfg_pd_exit,
  input  logic          wr_done,
  input  logic [RW-1:0] wr_rank,
  input  logic [BW-1:0] wr_bank,
  input  logic          rd_cas,
  input  logic [RW-1:0] rd_rank,
  input  logic [BW-1:0] rd_bank,
  input  logic          cke_chg,
  input  logic [RW-1:0] cke_rank,
  output logic [NB-1:0]    pre_ok,
  output logic [RANKS-1:0] rd_ok,
  output logic [RANKS-1:0] cke_ok
);
  // Clamped limits, named for the checker.
  cnt_t lim_wr_rec, lim_wr2rd, lim_rd2pre, lim_cke_w;

  // Decoded event strobes, one per target.
  logic [NB-1:0]    ev_wr_bank;
  logic [NB-1:0]    ev_rd_bank;
  logic [RANKS-1:0] ev_wr_rank;
  logic [RANKS-1:0] ev_cke_rank;

  // Timer expiry per target.
  logic [NB-1:0]    wrrec_done;
  logic [NB-1:0]    rd2pre_done;

  dtt_limits u_lim (
    .cfg_wr_rec (cfg_wr_rec),
    .cfg_wr2rd  (cfg_wr2rd),
    .cfg_rd2pre (cfg_rd2pre),
    .cfg_cke_w  (cfg_cke_w),
    .cfg_pd_exit(cfg_pd_exit),
    .lim_wr_rec (lim_wr_rec),
    .lim_wr2rd  (lim_wr2rd),
    .lim_rd2pre (lim_rd2pre),
    .lim_cke_w  (lim_cke_w)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    cnt_t w2r_cnt, cke_cnt;

    assign ev_wr_rank[r]  = wr_done && (wr_rank  == RW'(r));
    assign ev_cke_rank[r] = cke_chg && (cke_rank == RW'(r));

    dtt_countdown #(.W(CNT_W)) u_w2r (
      .clk(clk), .rst_n(rst_n), .start(ev_wr_rank[r]),
      .load_val(lim_wr2rd), .count(w2r_cnt), .expired(rd_ok[r])
    );

    dtt_countdown #(.W(CNT_W)) u_cke (
      .clk(clk), .rst_n(rst_n), .start(ev_cke_rank[r]),
      .load_val(lim_cke_w), .count(cke_cnt), .expired(cke_ok[r])
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam int unsigned IDX = r * BANKS + b;
      cnt_t wr_cnt, r2p_cnt;

      assign ev_wr_bank[IDX] = ev_wr_rank[r] && (wr_bank == BW'(b));
      assign ev_rd_bank[IDX] = rd_cas && (rd_rank == RW'(r)) && (rd_bank == BW'(b));

      dtt_countdown #(.W(CNT_W)) u_wrrec (
        .clk(clk), .rst_n(rst_n), .start(ev_wr_bank[IDX]),
        .load_val(lim_wr_rec), .count(wr_cnt), .expired(wrrec_done[IDX])
      );

      dtt_countdown #(.W(CNT_W)) u_r2p (
        .clk(clk), .rst_n(rst_n), .start(ev_rd_bank[IDX]),
        .load_val(lim_rd2pre), .count(r2p_cnt), .expired(rd2pre_done[IDX])
      );

      assign pre_ok[IDX] = wrrec_done[IDX] && rd2pre_done[IDX];
    end
  end
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker
  import dtt_pkg::*;
#(
  parameter int unsigned RANKS = 2,
  parameter int unsigned BANKS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             cfg_pd_exit,
  input cnt_t                   lim_wr_rec,
  input cnt_t                   lim_wr2rd,
  input cnt_t                   lim_rd2pre,
  input cnt_t                   lim_cke_w,
  input logic [RANKS*BANKS-1:0] ev_wr_bank,
  input logic [RANKS*BANKS-1:0] ev_rd_bank,
  input logic [RANKS-1:0]       ev_wr_rank,
  input logic [RANKS-1:0]       ev_cke_rank,
  input logic [RANKS*BANKS-1:0] pre_ok,
  input logic [RANKS-1:0]       rd_ok,
  input logic [RANKS-1:0]       cke_ok
);
  AST_WR_REC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr_rec >= cnt_t'(WR_MIN) && lim_wr_rec <= cnt_t'(WR_MAX)); // R1
  AST_WR2RD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_wr2rd >= cnt_t'(W2R_MIN) && lim_wr2rd <= cnt_t'(W2R_MAX)); // R2
  AST_RD2PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_rd2pre >= cnt_t'(R2P_MIN) && lim_rd2pre <= cnt_t'(R2P_MAX)); // R3
  AST_CKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lim_cke_w >= cnt_t'(CKE_MIN) &&
    (lim_cke_w <= cnt_t'(cfg_pd_exit) || lim_cke_w == cnt_t'(CKE_MIN))); // R4

  for (genvar i = 0; i < RANKS*BANKS; i++) begin : g_b
    AST_WR_CLOSES_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wr_bank[i] |=> !pre_ok[i]); // R5
    AST_RD_CLOSES_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd_bank[i] |=> !pre_ok[i]); // R6
    AST_PRE_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_ok[i] && !ev_wr_bank[i] && !ev_rd_bank[i]) |=> pre_ok[i]); // R11
  end

  for (genvar r = 0; r < RANKS; r++) begin : g_r
    AST_WR_CLOSES_RD: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wr_rank[r] |=> !rd_ok[r]); // R7
    AST_CKE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      ev_cke_rank[r] |=> !cke_ok[r]); // R8
    AST_RD_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ok[r] && !ev_wr_rank[r]) |=> rd_ok[r]); // R11
  end
endmodule

bind dram_turnaround_timer dtt_checker #(.RANKS(RANKS), .BANKS(BANKS)) u_chk (.*);

// File: tb/sim_dram_turnaround_timer.sv
`timescale 1ns/1ps
module sim_dram_turnaround_timer;
  localparam int RANKS = 2;
  localparam int BANKS = 4;
  localparam int NB    = RANKS * BANKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] cfg_wr_rec = 5'd6;
  logic [3:0] cfg_wr2rd = 4'd4, cfg_rd2pre = 4'd4, cfg_cke_w = 4'd3, cfg_pd_exit = 4'd5;
  logic wr_done = 1'b0, rd_cas = 1'b0, cke_chg = 1'b0;
  logic [0:0] wr_rank = '0, rd_rank = '0, cke_rank = '0;
  logic [1:0] wr_bank = '0, rd_bank = '0;
  logic [NB-1:0] pre_ok;
  logic [RANKS-1:0] rd_ok, cke_ok;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dram_turnaround_timer #(.RANKS(RANKS), .BANKS(BANKS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_rec(cfg_wr_rec), .cfg_wr2rd(cfg_wr2rd), .cfg_rd2pre(cfg_rd2pre),
    .cfg_cke_w(cfg_cke_w), .cfg_pd_exit(cfg_pd_exit),
    .wr_done(wr_done), .wr_rank(wr_rank), .wr_bank(wr_bank),
    .rd_cas(rd_cas), .rd_rank(rd_rank), .rd_bank(rd_bank),
    .cke_chg(cke_chg), .cke_rank(cke_rank),
    .pre_ok(pre_ok), .rd_ok(rd_ok), .cke_ok(cke_ok)
  );

  function automatic int expect_win(int v, int lo, int hi);
    int t;
    t = (v > hi) ? hi : v;
    return (t < lo) ? lo : t;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int low_pre1, low_rd0, low_pre6, low_cke1, others_bad;
    int exp_cke_hi;
    int low;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: every flag open after reset
    check("R10 pre_ok", int'(pre_ok), (1 << NB) - 1);
    check("R10 rd_ok", int'(rd_ok), 3);
    check("R10 cke_ok", int'(cke_ok), 3);

    // Sweep every raw count value; four timers run at once.
    for (int v = 0; v < 32; v++) begin
      cfg_wr_rec  = 5'(v);
      cfg_wr2rd   = 4'(v);
      cfg_rd2pre  = 4'(v + 3);
      cfg_cke_w   = 4'(v);
      cfg_pd_exit = 4'(15 - v);
      wr_done = 1'b1; wr_rank = 1'b0; wr_bank = 2'd1;      // flag index 1
      rd_cas  = 1'b1; rd_rank = 1'b1; rd_bank = 2'd2;      // flag index 6
      cke_chg = 1'b1; cke_rank = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_done = 1'b0; rd_cas = 1'b0; cke_chg = 1'b0;
      low_pre1 = 0; low_rd0 = 0; low_pre6 = 0; low_cke1 = 0; others_bad = 0;
      for (int c = 0; c < 20; c++) begin
        if (!pre_ok[1]) low_pre1++;
        if (!pre_ok[6]) low_pre6++;
        if (!rd_ok[0])  low_rd0++;
        if (!cke_ok[1]) low_cke1++;
        if ((pre_ok | 8'b0100_0010) != 8'hFF || !rd_ok[1] || !cke_ok[0]) others_bad++;
        @(negedge clk);
      end
      exp_cke_hi = ((15 - (v % 16)) < 3) ? 3 : (15 - (v % 16));
      check("R1/R5 write recovery", low_pre1, expect_win(v, 5, 16));
      check("R2/R7 write to read", low_rd0, expect_win(v % 16, 4, 8));
      check("R3/R6 read to precharge", low_pre6, expect_win((v + 3) % 16, 4, 8));
      check("R4/R8 cke width", low_cke1, expect_win(v % 16, 3, exp_cke_hi));
      check("R11 untouched flags", others_bad, 0);
    end

    // R6: write at cycle 0 (count 10), read at cycle 8 (count 6): closed 14 cycles.
    cfg_wr_rec = 5'd10; cfg_rd2pre = 4'd6; cfg_wr2rd = 4'd8;
    wr_rank = 1'b1; wr_bank = 2'd3; rd_rank = 1'b1; rd_bank = 2'd3;
    low = 0;
    for (int c = 0; c < 24; c++) begin
      wr_done = (c == 0);
      rd_cas  = (c == 8);
      @(posedge clk);
      @(negedge clk);
      wr_done = 1'b0; rd_cas = 1'b0;
      if (!pre_ok[7]) low++;
    end
    check("R6 both timers gate precharge", low, 14);

    // R9: second write at cycle 5 restarts count 8: closed 13 cycles.
    wr_rank = 1'b0; wr_bank = 2'd0;
    low = 0;
    for (int c = 0; c < 24; c++) begin
      wr_done = (c == 0) || (c == 5);
      @(posedge clk);
      @(negedge clk);
      wr_done = 1'b0;
      if (!rd_ok[0]) low++;
    end
    check("R9 restart write to read", low, 13);

    // R9: CKE change again at cycle 2 with width 5 (limit 9): closed 7 cycles.
    cfg_cke_w = 4'd5; cfg_pd_exit = 4'd9; cke_rank = 1'b0;
    low = 0;
    for (int c = 0; c < 16; c++) begin
      cke_chg = (c == 0) || (c == 2);
      @(posedge clk);
      @(negedge clk);
      cke_chg = 1'b0;
      if (!cke_ok[0]) low++;
    end
    check("R9 restart cke", low, 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule